// File: doc/BRIEF.md
# Asynchronous Serial Port with Byte-Addressed Registers

This block is an asynchronous serial transmitter and receiver that sits behind a simple single-cycle register port. Software sets the frame options and the bit rate, writes a byte to the transmit holding register and polls status flags. It reads received bytes from the receive holding register. The transmit side moves the held byte into a shift register and sends it as one start bit, eight data bits (least significant first), an optional parity bit and one stop bit. The receive side finds the falling edge of a start bit, samples each bit at its middle and hands the byte to the register file.

Error flags are cleared by writing zero to them, and a written one leaves them as they are. Framing and parity errors are also tallied in two saturating counters inside a 16-bit line-status register, so firmware can track line quality without catching each event. Writes take effect at the clock edge on which `wr_en` is high. `rd_data` is combinational from `addr`.

The transmitter has states TX_IDLE, TX_START, TX_DATA, TX_PAR and TX_STOP:
- TX_IDLE to TX_START when transmit is enabled and a byte is held (load).
- TX_START to TX_DATA at the end of a bit.
- TX_DATA to TX_PAR, or to TX_STOP when parity is off, after the last data bit.
- TX_PAR to TX_STOP at the end of a bit.
- TX_STOP to TX_START when another byte is held, otherwise to TX_IDLE.

The receiver has states RX_IDLE, RX_START, RX_DATA, RX_PAR and RX_STOP:
- RX_IDLE to RX_START on a falling edge while receive is enabled.
- RX_START back to RX_IDLE when the mid-bit sample is high (false start), otherwise to RX_DATA at the end of the bit.
- RX_DATA to RX_PAR or RX_STOP after the last data bit.
- RX_PAR to RX_STOP at the end of a bit.
- RX_STOP to RX_IDLE at the mid-bit sample, which completes the byte.
- Every receive state returns to RX_IDLE when receive is disabled.

Top module: `async_serial_port`

## Requirements
- R1: Register offsets are:
  - 0x00 frame mode: [1:0] clock prescale select, [4] odd parity, [5] parity enable.
  - 0x01 rate divisor.
  - 0x02 control: [4] receive enable, [5] transmit enable.
  - 0x03 transmit holding.
  - 0x04 status.
  - 0x05 receive holding.
  - 0x07 extended mode: [6] fast sampling.
  - 0x18 line status, 16 bits.

  After reset, every register reads 0 except status, which reads 0x84. Unmapped offsets read 0.
- R2: One sixteenth of a bit lasts (divisor+1) × 4^prescale clocks, and twice that when extended-mode bit 6 is 0. A bit therefore lasts 16 times that value.
- R3: The line idles high. A frame is one low start bit, eight data bits LSB first, a parity bit when enabled, and one high stop bit. With transmit enabled and the transmitter idle, the start bit appears on the second clock edge after the write to 0x03.
- R4: Status bit 7 (holding empty) clears on a write to 0x03 and sets when the byte moves to the shift register. Status bit 2 (transmit end) clears at that move, and sets when a stop bit ends with no byte held.
- R5: A byte held when a stop bit ends starts its start bit on the next cycle, with no idle gap.
- R6: With control bit 5 clear, no frame starts, the line stays high and the held byte stays pending until transmit is enabled.
- R7: The receiver samples at sixteenth number 8 of each bit, counted from the start edge. A completed byte is placed in 0x05 and sets status bit 6 (receive full).
- R8: With control bit 4 clear, the line is ignored: status bit 6 and register 0x05 do not change.
- R9: A byte that completes while status bit 6 is 1 is discarded. It sets status bit 5 and line-status bit 0 (overrun).
- R10: A low stop-bit sample sets status bit 4 and increments the framing count in line-status bits [6:2]. The count saturates at 31.
- R11: With mode bit 5 set, parity is even when mode bit 4 is 0 and odd when it is 1. A mismatch sets status bit 3 and increments the parity count in line-status bits [12:8]. The count saturates at 31.
- R12: Writing 0 to status bits 3, 4, 5, 6 or 7, or to line-status bit 0, clears that bit. Writing 1 has no effect, and status bit 2 is read-only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 5 | Byte offset of the register |
| wr_data | input | 8 | Write data |
| rd_data | output | 16 | Read data for `addr`, combinational |
| rxd | input | 1 | Serial input line |
| txd | output | 1 | Serial output line |

## Verification
The transmit line is checked on every cycle against a queue-based reference under several stimulus patterns:
- Alternating and mixed data bytes, which would show bit-order or shift faults.
- Even and odd parity, which would show inverted parity sense.
- Three different bit-period settings, which would show a wrong prescale or sampling-mode decode.
- Back-to-back bytes, which would expose an idle gap or a lost byte.
- Transmit disabled, which must hold the byte pending.

The receive side is driven with clean frames, frames while receive is off, frames that overrun a full register, frames with a low stop bit and frames with a wrong parity bit. The last two are repeated past 32 times to reach counter saturation.

// File: rtl/asp_pkg.sv
`timescale 1ns/1ps
package asp_pkg;
    localparam int OFF_MODE = 'h00;
    localparam int OFF_RATE = 'h01;
    localparam int OFF_CTRL = 'h02;
    localparam int OFF_TXH  = 'h03;
    localparam int OFF_STAT = 'h04;
    localparam int OFF_RXH  = 'h05;
    localparam int OFF_EXT  = 'h07;
    localparam int OFF_LINE = 'h18;
    localparam int OVS       = 16; // sixteenths per bit
    localparam int SAMPLE_AT = 7;  // zero-based index of the 8th sixteenth

    typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} tx_state_t;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_state_t;
endpackage

// File: rtl/asp_baud.sv
`timescale 1ns/1ps
module asp_baud #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PER_W-1:0] period,
    output logic             tick
);
    logic [PER_W-1:0] cnt;

    assign tick = run && !restart && (cnt == period - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt <= '0;
        else if (restart || !run || tick) cnt <= '0;
        else                             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/asp_tx.sv
`timescale 1ns/1ps
module asp_tx
    import asp_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int PER_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 te,
    input  logic [PER_W-1:0]     period,
    input  logic                 par_en,
    input  logic                 par_odd,
    input  logic                 hold_valid,
    input  logic [DATA_BITS-1:0] hold_byte,
    output logic                 load,
    output logic                 tend,
    output logic                 txd
);
    localparam int SUB_W = $clog2(OVS);
    localparam int BIT_W = $clog2(DATA_BITS);

    tx_state_t state, nxt;
    logic [SUB_W-1:0]     sub;
    logic [BIT_W-1:0]     bitn;
    logic [DATA_BITS-1:0] shreg;
    logic                 par_bit, tick, bit_end, go_idle;

    assign go_idle = (state == TX_IDLE) && te && hold_valid;
    assign bit_end = tick && (sub == SUB_W'(OVS - 1));

    asp_baud #(.PER_W(PER_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(state != TX_IDLE),
        .restart(go_idle), .period(period), .tick(tick)
    );

    always_comb begin
        nxt  = state;
        load = 1'b0;
        unique case (state)
            TX_IDLE:  if (go_idle) begin nxt = TX_START; load = 1'b1; end
            TX_START: if (bit_end) nxt = TX_DATA;
            TX_DATA:  if (bit_end && bitn == BIT_W'(DATA_BITS - 1)) nxt = par_en ? TX_PAR : TX_STOP;
            TX_PAR:   if (bit_end) nxt = TX_STOP;
            TX_STOP:  if (bit_end) begin
                          if (te && hold_valid) begin nxt = TX_START; load = 1'b1; end
                          else nxt = TX_IDLE;
                      end
            default:  nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub <= '0; bitn <= '0; shreg <= '0; par_bit <= 1'b0; tend <= 1'b1;
        end else begin
            if (load) begin
                shreg   <= hold_byte;
                par_bit <= (^hold_byte) ^ par_odd;
                sub     <= '0;
                bitn    <= '0;
                tend    <= 1'b0;
            end else if (tick) begin
                sub <= sub + 1'b1;
                if (bit_end && state == TX_DATA) begin
                    bitn  <= bitn + 1'b1;
                    shreg <= {1'b0, shreg[DATA_BITS-1:1]};
                end
            end
            if (state == TX_STOP && nxt == TX_IDLE) tend <= 1'b1;
        end
    end

    always_comb begin
        unique case (state)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shreg[0];
            TX_PAR:   txd = par_bit;
            default:  txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/asp_rx.sv
`timescale 1ns/1ps
module asp_rx
    import asp_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int PER_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 re,
    input  logic [PER_W-1:0]     period,
    input  logic                 par_en,
    input  logic                 par_odd,
    input  logic                 rxd,
    output logic                 done,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic                 frame_err,
    output logic                 par_err,
    output logic                 busy
);
    localparam int SUB_W = $clog2(OVS);
    localparam int BIT_W = $clog2(DATA_BITS);

    rx_state_t state, nxt;
    logic [2:0]           sync;
    logic [SUB_W-1:0]     sub;
    logic [BIT_W-1:0]     bitn;
    logic [DATA_BITS-1:0] shreg;
    logic                 par_rx, lvl, fall, start, tick, mid, bit_end;

    assign lvl     = sync[1];
    assign fall    = sync[2] && !sync[1];
    assign start   = (state == RX_IDLE) && re && fall;
    assign mid     = tick && (sub == SUB_W'(SAMPLE_AT));
    assign bit_end = tick && (sub == SUB_W'(OVS - 1));

    asp_baud #(.PER_W(PER_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(state != RX_IDLE),
        .restart(start), .period(period), .tick(tick)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:  if (start) nxt = RX_START;
            RX_START: if (mid && lvl) nxt = RX_IDLE;
                      else if (bit_end) nxt = RX_DATA;
            RX_DATA:  if (bit_end && bitn == BIT_W'(DATA_BITS - 1)) nxt = par_en ? RX_PAR : RX_STOP;
            RX_PAR:   if (bit_end) nxt = RX_STOP;
            RX_STOP:  if (mid) nxt = RX_IDLE;
            default:  nxt = RX_IDLE;
        endcase
        if (!re) nxt = RX_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync <= 3'b111; sub <= '0; bitn <= '0; shreg <= '0; par_rx <= 1'b0;
        end else begin
            sync <= {sync[1:0], rxd};
            if (start) begin
                sub  <= '0;
                bitn <= '0;
            end else if (tick) begin
                sub <= sub + 1'b1;
                if (mid && state == RX_DATA) shreg <= {lvl, shreg[DATA_BITS-1:1]};
                if (mid && state == RX_PAR)  par_rx <= lvl;
                if (bit_end && state == RX_DATA) bitn <= bitn + 1'b1;
            end
        end
    end

    assign done      = (state == RX_STOP) && mid && re;
    assign rx_byte   = shreg;
    assign frame_err = !lvl;
    assign par_err   = par_en && (par_rx != ((^shreg) ^ par_odd));
    assign busy      = (state != RX_IDLE);
endmodule

// File: rtl/async_serial_port.sv
`timescale 1ns/1ps
module async_serial_port
    import asp_pkg::*;
#(
    parameter int DW     = 8,
    parameter int BUS_W  = 16,
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wr_data,
    output logic [BUS_W-1:0]  rd_data,
    input  logic              rxd,
    output logic              txd
);
    localparam int PER_W = DW + 8;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [DW-1:0] mode_q, rate_q, ctrl_q, ext_q, txh_q, rxh_q;
    logic tdre_q, rdrf_q, orer_q, fer_q, per_q, lsr_orer_q;
    logic [CNT_W-1:0] fcnt_q, pcnt_q;
    logic [2:0] shamt;
    logic [PER_W-1:0] period;
    logic te, re, tx_load, tend, rx_done, frame_err, par_err, rx_busy;
    logic [DW-1:0] rx_byte;
    logic wr_mode, wr_rate, wr_ctrl, wr_txh, wr_stat, wr_ext, wr_line;

    assign wr_mode = wr_en && addr == ADDR_W'(OFF_MODE);
    assign wr_rate = wr_en && addr == ADDR_W'(OFF_RATE);
    assign wr_ctrl = wr_en && addr == ADDR_W'(OFF_CTRL);
    assign wr_txh  = wr_en && addr == ADDR_W'(OFF_TXH);
    assign wr_stat = wr_en && addr == ADDR_W'(OFF_STAT);
    assign wr_ext  = wr_en && addr == ADDR_W'(OFF_EXT);
    assign wr_line = wr_en && addr == ADDR_W'(OFF_LINE);

    assign te     = ctrl_q[5];
    assign re     = ctrl_q[4];
    assign shamt  = {mode_q[1:0], 1'b0} + {2'b00, ~ext_q[6]};
    assign period = (PER_W'(rate_q) + 1'b1) << shamt;

    asp_tx #(.DATA_BITS(DW), .PER_W(PER_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .te(te), .period(period),
        .par_en(mode_q[5]), .par_odd(mode_q[4]),
        .hold_valid(!tdre_q), .hold_byte(txh_q),
        .load(tx_load), .tend(tend), .txd(txd)
    );

    asp_rx #(.DATA_BITS(DW), .PER_W(PER_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .re(re), .period(period),
        .par_en(mode_q[5]), .par_odd(mode_q[4]), .rxd(rxd),
        .done(rx_done), .rx_byte(rx_byte), .frame_err(frame_err),
        .par_err(par_err), .busy(rx_busy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0; rate_q <= '0; ctrl_q <= '0; ext_q <= '0;
            txh_q <= '0; rxh_q <= '0;
            tdre_q <= 1'b1; rdrf_q <= 1'b0; orer_q <= 1'b0; fer_q <= 1'b0;
            per_q <= 1'b0; lsr_orer_q <= 1'b0; fcnt_q <= '0; pcnt_q <= '0;
        end else begin
            if (wr_mode) mode_q <= wr_data;
            if (wr_rate) rate_q <= wr_data;
            if (wr_ctrl) ctrl_q <= wr_data;
            if (wr_ext)  ext_q  <= wr_data;
            if (wr_txh)  txh_q  <= wr_data;

            if (wr_txh)                     tdre_q <= 1'b0;
            else if (tx_load)               tdre_q <= 1'b1;
            else if (wr_stat && !wr_data[7]) tdre_q <= 1'b0;

            if (rx_done && !rdrf_q) begin
                rdrf_q <= 1'b1;
                rxh_q  <= rx_byte;
            end else if (wr_stat && !wr_data[6]) rdrf_q <= 1'b0;

            if (rx_done && rdrf_q)           orer_q <= 1'b1;
            else if (wr_stat && !wr_data[5]) orer_q <= 1'b0;

            if (rx_done && rdrf_q)           lsr_orer_q <= 1'b1;
            else if (wr_line && !wr_data[0]) lsr_orer_q <= 1'b0;

            if (rx_done && frame_err)        fer_q <= 1'b1;
            else if (wr_stat && !wr_data[4]) fer_q <= 1'b0;

            if (rx_done && par_err)          per_q <= 1'b1;
            else if (wr_stat && !wr_data[3]) per_q <= 1'b0;

            if (rx_done && frame_err && fcnt_q != CNT_MAX) fcnt_q <= fcnt_q + 1'b1;
            if (rx_done && par_err && pcnt_q != CNT_MAX)   pcnt_q <= pcnt_q + 1'b1;
        end
    end

    always_comb begin
        case (addr)
            ADDR_W'(OFF_MODE): rd_data = BUS_W'(mode_q);
            ADDR_W'(OFF_RATE): rd_data = BUS_W'(rate_q);
            ADDR_W'(OFF_CTRL): rd_data = BUS_W'(ctrl_q);
            ADDR_W'(OFF_TXH):  rd_data = BUS_W'(txh_q);
            ADDR_W'(OFF_STAT): rd_data = BUS_W'({tdre_q, rdrf_q, orer_q, fer_q, per_q, tend, 2'b00});
            ADDR_W'(OFF_RXH):  rd_data = BUS_W'(rxh_q);
            ADDR_W'(OFF_EXT):  rd_data = BUS_W'(ext_q);
            ADDR_W'(OFF_LINE): rd_data = BUS_W'({pcnt_q, 1'b0, fcnt_q, 1'b0, lsr_orer_q});
            default:           rd_data = '0;
        endcase
    end
endmodule

// File: rtl/asp_checker.sv
`timescale 1ns/1ps
module asp_checker #(
    parameter int DW    = 8,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_load,
    input logic             wr_txh,
    input logic             tdre,
    input logic             tend,
    input logic             txd,
    input logic             rx_done,
    input logic             rdrf,
    input logic             orer,
    input logic [DW-1:0]    rxh,
    input logic [CNT_W-1:0] fcnt,
    input logic [CNT_W-1:0] pcnt,
    input logic             re,
    input logic             rx_busy
);
    localparam logic [CNT_W-1:0] TOP = '1;

    AST_EMPTY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load && !wr_txh |=> tdre); // R4
    AST_LINE_HIGH_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        tend |-> txd); // R3
    AST_OVERRUN_DISCARDS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done && rdrf |=> orer && $stable(rxh)); // R9
    AST_FCNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        fcnt == TOP |=> fcnt == TOP); // R10
    AST_PCNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt == TOP |=> pcnt == TOP); // R11
    AST_RX_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !re |=> !rx_busy); // R8
endmodule

bind async_serial_port asp_checker #(.DW(DW), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_load(tx_load), .wr_txh(wr_txh),
    .tdre(tdre_q), .tend(tend), .txd(txd), .rx_done(rx_done),
    .rdrf(rdrf_q), .orer(orer_q), .rxh(rxh_q), .fcnt(fcnt_q),
    .pcnt(pcnt_q), .re(re), .rx_busy(rx_busy)
);

// File: tb/async_serial_port_test.sv
`timescale 1ns/1ps
module async_serial_port_test;
    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rxd = 1'b1;
    logic [4:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [15:0] rd_data;
    logic txd;
    int compared = 0, mismatched = 0;

    async_serial_port uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .rxd(rxd), .txd(txd));

    always #10 clk = ~clk;

    // behavioural reference of the transmit side
    bit lineq[$];
    bit exp_txd = 1'b1, m_pv = 1'b0, m_tend = 1'b1, m_te = 1'b0;
    bit m_pe = 1'b0, m_pm = 1'b0, m_bgdm = 1'b0;
    int m_cks = 0, m_brr = 0;
    logic [7:0] m_pb = '0;

    function automatic void push_level(bit v);
        int per;
        per = (m_brr + 1) * (4 ** m_cks) * (m_bgdm ? 1 : 2);
        for (int i = 0; i < 16 * per; i++) lineq.push_back(v);
    endfunction

    function automatic void push_frame(logic [7:0] b);
        push_level(1'b0);
        for (int i = 0; i < 8; i++) push_level(b[i]);
        if (m_pe) push_level((^b) ^ m_pm);
        push_level(1'b1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            lineq.delete(); exp_txd = 1'b1; m_pv = 1'b0; m_tend = 1'b1; m_te = 1'b0;
            m_pe = 1'b0; m_pm = 1'b0; m_bgdm = 1'b0; m_cks = 0; m_brr = 0; m_pb = '0;
        end else begin
            if (lineq.size() > 0) exp_txd = lineq.pop_front();
            else if (m_pv && m_te) begin
                push_frame(m_pb); m_pv = 1'b0; m_tend = 1'b0; exp_txd = lineq.pop_front();
            end else begin
                exp_txd = 1'b1; m_tend = 1'b1;
            end
            if (wr_en) begin
                case (addr)
                    5'h00: begin m_cks = int'(wr_data[1:0]); m_pm = wr_data[4]; m_pe = wr_data[5]; end
                    5'h01: m_brr = int'(wr_data);
                    5'h02: m_te = wr_data[5];
                    5'h03: begin m_pb = wr_data; m_pv = 1'b1; end
                    5'h04: if (!wr_data[7]) m_pv = 1'b1;
                    5'h07: m_bgdm = wr_data[6];
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            compared++;
            if (txd !== exp_txd) begin
                mismatched++;
                $display("FAIL R2/R3 txd at %0t: actual %0b expected %0b", $time, txd, exp_txd);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] v);
        @(negedge clk); addr = a; #1; v = rd_data;
    endtask

    task automatic chk_tx_status(input string tag);
        logic [15:0] v;
        rd(5'h04, v);
        chk({tag, " empty"}, int'(v[7]), int'(!m_pv));
        chk({tag, " end"}, int'(v[2]), int'(m_tend));
    endtask

    task automatic wait_tx_done();
        while (lineq.size() != 0 || (m_pv && m_te)) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic send_rx(input logic [7:0] b, input bit with_par, input bit par_v, input bit stop_v);
        @(negedge clk); rxd = 1'b0; repeat (15) @(negedge clk);
        for (int i = 0; i < 8; i++) begin rxd = b[i]; repeat (16) @(negedge clk); end
        if (with_par) begin rxd = par_v; repeat (16) @(negedge clk); end
        rxd = stop_v; repeat (16) @(negedge clk);
        rxd = 1'b1; repeat (24) @(negedge clk);
    endtask

    initial begin
        #(20 * 190000);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int n;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values and map
        rd(5'h00, v); chk("R1 mode reset", int'(v), 0);
        rd(5'h01, v); chk("R1 rate reset", int'(v), 0);
        rd(5'h02, v); chk("R1 ctrl reset", int'(v), 0);
        rd(5'h04, v); chk("R1 status reset", int'(v), 'h84);
        rd(5'h05, v); chk("R1 rx holding reset", int'(v), 0);
        rd(5'h07, v); chk("R1 ext reset", int'(v), 0);
        rd(5'h18, v); chk("R1 line status reset", int'(v), 0);
        rd(5'h06, v); chk("R1 unmapped", int'(v), 0);

        // R3 R4 basic frame, 16 clocks per bit
        wr(5'h07, 8'h40); wr(5'h02, 8'h30);
        wr(5'h03, 8'h55);
        chk_tx_status("R4 after load");
        wait_tx_done();
        chk_tx_status("R4 after frame");
        // R11 parity on the transmit side, even then odd
        wr(5'h00, 8'h20); wr(5'h03, 8'hA3); wait_tx_done();
        wr(5'h00, 8'h30); wr(5'h03, 8'h0F); wait_tx_done();
        wr(5'h00, 8'h00);
        // R5 back to back
        wr(5'h03, 8'h12);
        do rd(5'h04, v); while (!v[7]);
        wr(5'h03, 8'h34);
        chk_tx_status("R5 second byte held");
        wait_tx_done();
        chk_tx_status("R5 after pair");
        // R6 transmit disabled
        wr(5'h02, 8'h10); wr(5'h03, 8'h77);
        repeat (200) @(negedge clk);
        chk("R6 line idle", int'(txd), 1);
        chk_tx_status("R6 byte pending");
        wr(5'h02, 8'h30); wait_tx_done();
        chk_tx_status("R6 sent after enable");
        // R12 write zero clears holding empty
        wr(5'h02, 8'h10); wr(5'h04, 8'h7F);
        chk_tx_status("R12 empty cleared");
        wr(5'h02, 8'h30); wait_tx_done();
        // R2 prescale 1, divisor 1, fast sampling: 8 clocks per sixteenth
        wr(5'h00, 8'h01); wr(5'h01, 8'h01);
        wr(5'h03, 8'hC7);
        while (txd) @(negedge clk);
        n = 0;
        while (!txd) begin n++; @(negedge clk); end
        chk("R2 start bit length", n, 128);
        wait_tx_done();
        // R2 slow sampling, no prescale: 2 clocks per sixteenth
        wr(5'h00, 8'h00); wr(5'h01, 8'h00); wr(5'h07, 8'h00);
        wr(5'h03, 8'h39); wait_tx_done();
        wr(5'h07, 8'h40);

        // R7 receive
        send_rx(8'h5A, 1'b0, 1'b0, 1'b1);
        rd(5'h05, v); chk("R7 rx byte", int'(v), 'h5A);
        rd(5'h04, v); chk("R7 rx full, no errors", int'(v[6:3]), 'h8);
        wr(5'h04, 8'hBF);
        rd(5'h04, v); chk("R12 full cleared, empty kept", int'({v[7], v[6]}), 2);
        // R8 receiver off
        wr(5'h02, 8'h20);
        send_rx(8'h11, 1'b0, 1'b0, 1'b1);
        rd(5'h04, v); chk("R8 no full flag", int'(v[6]), 0);
        rd(5'h05, v); chk("R8 holding kept", int'(v), 'h5A);
        wr(5'h02, 8'h30);
        // R9 overrun
        send_rx(8'h21, 1'b0, 1'b0, 1'b1);
        send_rx(8'h22, 1'b0, 1'b0, 1'b1);
        rd(5'h04, v); chk("R9 overrun status", int'(v[5]), 1);
        rd(5'h18, v); chk("R9 overrun line", int'(v[0]), 1);
        rd(5'h05, v); chk("R9 first byte kept", int'(v), 'h21);
        wr(5'h04, 8'hDF);
        rd(5'h04, v); chk("R12 overrun cleared, full kept", int'({v[6], v[5]}), 2);
        wr(5'h18, 8'h00);
        rd(5'h18, v); chk("R12 line overrun cleared", int'(v[0]), 0);
        wr(5'h04, 8'hBF);
        // R10 framing
        send_rx(8'h44, 1'b0, 1'b0, 1'b0);
        rd(5'h04, v); chk("R10 framing flag", int'(v[4]), 1);
        rd(5'h18, v); chk("R10 framing count", int'(v[6:2]), 1);
        wr(5'h04, 8'hEF);
        rd(5'h04, v); chk("R12 framing cleared", int'(v[4]), 0);
        for (int i = 0; i < 32; i++) send_rx(8'h44, 1'b0, 1'b0, 1'b0);
        rd(5'h18, v); chk("R10 framing count saturates", int'(v[6:2]), 31);
        wr(5'h04, 8'h87);
        // R11 parity receive
        wr(5'h00, 8'h20);
        send_rx(8'h33, 1'b1, 1'b0, 1'b1);
        rd(5'h04, v); chk("R11 even parity good", int'(v[3]), 0);
        send_rx(8'h33, 1'b1, 1'b1, 1'b1);
        rd(5'h04, v); chk("R11 even parity bad", int'(v[3]), 1);
        rd(5'h18, v); chk("R11 parity count", int'(v[12:8]), 1);
        wr(5'h04, 8'hF7);
        wr(5'h00, 8'h30);
        send_rx(8'h33, 1'b1, 1'b1, 1'b1);
        rd(5'h04, v); chk("R11 odd parity good", int'(v[3]), 0);
        for (int i = 0; i < 32; i++) send_rx(8'h33, 1'b1, 1'b0, 1'b1);
        rd(5'h18, v); chk("R11 parity count saturates", int'(v[12:8]), 31);
        rd(5'h18, v); chk("R10 framing count unchanged", int'(v[6:2]), 31);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule